// File: doc/BRIEF.md
# Scatter-Gather DMA Descriptor Engine

This block is one DMA channel that copies bytes between a host-side address space and a local address space over a single word-wide memory port with request/acknowledge handshaking. Software programs a small register set: mode, host address, local address, byte count, next pointer and a command/status byte. It then sets the start bit. In direct mode the channel makes one transfer from those registers. In chained mode it walks a linked list of 16-byte descriptors kept in either address space. It loads each descriptor into its working registers and moves the data. It may write a zero back over the descriptor's count word, and then follows the link until it reaches a link marked as the last.

The copy runs in 32-bit beats. Each beat is a read from the source space followed by a write to the destination space. Every beat moves four bytes except a final short beat, which carries only the remaining bytes on the low byte lanes. A sticky interrupt flag reports completion or the end of a flagged descriptor. An abort request stops the channel at the next safe point.

Top module: `sgdma_chan`

## Requirements
- R1: After reset the status byte reads 0x10 (done=1, enable=0). The irq output is 0, mem_req is 0, and every configuration register reads 0.
- R2: Writes to register indices 0 to 4 take effect only while the channel is idle. While a transfer runs they are ignored, and the mode and address registers keep the values the engine gives them.
- R3: A status write with bit 1 (start) and bit 0 (enable) both set, made while idle, starts the channel and clears done on the next cycle. A start written with bit 0 clear is ignored: done stays 1 and no memory request is made.
- R4: With mode bit 9 clear, one transfer runs from the host address, local address and count registers. Next-pointer bit 3 selects the direction: 1 is local to host, 0 is host to local.
- R5: Each beat reads one word from the source and writes it to the destination. A full beat carries byte enables 0xF. A final beat of n<4 bytes carries the low n enables. The host address rises by 4 per beat. The local address also rises by 4, unless mode bit 11 holds it constant. A zero count moves nothing.
- R6: With mode bit 9 set, the engine fetches a descriptor from the 16-byte aligned address next[31:4]<<4, in host space if next bit 0 is 1 and otherwise in local space. The descriptor's four words are host address, local address, byte count (only bits 22:0 used) and next pointer.
- R7: After each descriptor the engine follows its next pointer. It stops after a descriptor whose next-pointer bit 1 (end of chain) is set. Bit 3 of each descriptor's own next pointer gives that descriptor's direction.
- R8: With mode bit 16 set in chained mode, the engine writes zero, with all byte enables, to the count word (offset 8) of each finished descriptor. With bit 16 clear, descriptor memory is left unchanged.
- R9: irq is set when a transfer completes with mode bit 10 set. In chained mode it is also set after any descriptor whose next-pointer bit 2 is set. It stays set until a status write with bit 3 set.
- R10: A status write with bit 2 (abort) while enable is 1 and a transfer is running stops the channel at the next beat boundary. The count register then holds the bytes not moved, done is set and irq is not raised. An abort while enable is 0 is ignored.
- R11: When a transfer completes, done is set and the count register reads 0.
- R12: Register indices are 0 mode, 1 host address, 2 local address, 3 byte count, 4 next pointer and 5 status. Status reads bit 0 enable and bit 4 done; all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_host | output | 1 | 1 = host space, 0 = local space |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_be | output | DATA_W/8 | Byte enables |
| mem_ack | input | 1 | One-cycle acknowledge |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack |
| irq | output | 1 | Sticky channel interrupt flag |

## Verification
The bench sends short odd counts that end in a partial beat. A design with wrong byte enables would write past the last byte. It runs a zero count and a held local address. A held-address error would instead spread the data over consecutive local words. Random chains mix descriptor spaces, directions, junk in the upper count bits and count write-back. These expose a wrong word order, a count mask that lets the upper bits through, a stray write-back, or a lost link. Aborts with enable set and with enable clear test that the channel stops exactly on a beat boundary, or runs on, as required. They also test that a start written without enable never touches memory.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_XFER,
      ST_RD,
      ST_WR,
      ST_END,
      ST_WB,
      ST_POST
   } seq_state_t;

   // register indices
   localparam int IDX_MODE  = 0;
   localparam int IDX_HADDR = 1;
   localparam int IDX_LADDR = 2;
   localparam int IDX_COUNT = 3;
   localparam int IDX_NEXT  = 4;
   localparam int IDX_CSR   = 5;

   // mode bits
   localparam int MB_CHAIN   = 9;
   localparam int MB_DONE_IE = 10;
   localparam int MB_HOLD    = 11;
   localparam int MB_CLR_CNT = 16;

   // link flag bits in the next pointer
   localparam int NF_HOST = 0;
   localparam int NF_EOC  = 1;
   localparam int NF_TCI  = 2;
   localparam int NF_L2H  = 3;

   // status byte bits
   localparam int CS_EN    = 0;
   localparam int CS_GO    = 1;
   localparam int CS_ABORT = 2;
   localparam int CS_ACK   = 3;
   localparam int CS_DONE  = 4;

endpackage

// File: rtl/sgdma_beat.sv
module sgdma_beat #(
   parameter int CNT_W  = 23,
   parameter int DATA_W = 32
) (
   input  logic [CNT_W-1:0]           cnt,
   output logic [DATA_W/8-1:0]        be,
   output logic [$clog2(DATA_W/8):0]  step,
   output logic                       zero
);
   localparam int BYTES = DATA_W / 8;
   localparam int SW    = $clog2(BYTES);

   logic full;
   assign full = (cnt >= CNT_W'(BYTES));
   assign zero = (cnt == '0);

   for (genvar i = 0; i < BYTES; i++) begin : g_lane
      assign be[i] = full || (cnt > CNT_W'(i));
   end

   assign step = full ? (SW+1)'(BYTES) : {1'b0, cnt[SW-1:0]};

endmodule

// File: rtl/sgdma_regs.sv
module sgdma_regs
   import sgdma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 23,
   parameter int DATA_W = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      host_we,
   input  logic [2:0]                host_idx,
   input  logic [31:0]               host_wdata,
   input  logic                      busy,
   input  logic                      ld_en,
   input  logic [1:0]                ld_idx,
   input  logic [DATA_W-1:0]         ld_data,
   input  logic                      adv,
   input  logic [$clog2(DATA_W/8):0] step,
   output logic [31:0]               mode,
   output logic [ADDR_W-1:0]         haddr,
   output logic [ADDR_W-1:0]         laddr,
   output logic [CNT_W-1:0]          cnt,
   output logic [ADDR_W-1:0]         nptr
);
   localparam int BYTES = DATA_W / 8;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode  <= '0;
         haddr <= '0;
         laddr <= '0;
         cnt   <= '0;
         nptr  <= '0;
      end else begin
         if (host_we && !busy) begin
            case (int'(host_idx))
               IDX_MODE:  mode  <= host_wdata;
               IDX_HADDR: haddr <= host_wdata[ADDR_W-1:0];
               IDX_LADDR: laddr <= host_wdata[ADDR_W-1:0];
               IDX_COUNT: cnt   <= host_wdata[CNT_W-1:0];
               IDX_NEXT:  nptr  <= host_wdata[ADDR_W-1:0];
               default: ;
            endcase
         end
         if (ld_en) begin
            case (ld_idx)
               2'd0: haddr <= ld_data[ADDR_W-1:0];
               2'd1: laddr <= ld_data[ADDR_W-1:0];
               2'd2: cnt   <= ld_data[CNT_W-1:0];
               default: nptr <= ld_data[ADDR_W-1:0];
            endcase
         end
         if (adv) begin
            haddr <= haddr + ADDR_W'(BYTES);
            if (!mode[MB_HOLD]) laddr <= laddr + ADDR_W'(BYTES);
            cnt <= cnt - CNT_W'(step);
         end
      end
   end

   AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && host_we && int'(host_idx) == IDX_MODE) |=> $stable(mode)); // R2

endmodule

// File: rtl/sgdma_ctrl.sv
module sgdma_ctrl
   import sgdma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 23,
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  csr_we,
   input  logic [7:0]            csr_wdata,
   input  logic [31:0]           mode,
   input  logic [ADDR_W-1:0]     haddr,
   input  logic [ADDR_W-1:0]     laddr,
   input  logic [ADDR_W-1:0]     nptr,
   input  logic                  cnt_zero,
   input  logic [DATA_W/8-1:0]   beat_be,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic                  mem_host,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [DATA_W-1:0]     mem_wdata,
   output logic [DATA_W/8-1:0]   mem_be,
   input  logic                  mem_ack,
   input  logic [DATA_W-1:0]     mem_rdata,
   output logic                  ld_en,
   output logic [1:0]            ld_idx,
   output logic [DATA_W-1:0]     ld_data,
   output logic                  adv,
   output logic                  busy,
   output logic [7:0]            csr_rdata,
   output logic                  irq
);
   seq_state_t          state_q;
   logic [1:0]          widx_q;
   logic [ADDR_W-1:0]   dsc_addr_q;
   logic                dsc_host_q;
   logic [DATA_W-1:0]   data_q;
   logic                en_q, done_q, irq_q, abort_q;

   logic chain, dir_l2h, go_req, abort_req, stop_now;

   assign chain     = mode[MB_CHAIN];
   assign dir_l2h   = nptr[NF_L2H];
   assign busy      = (state_q != ST_IDLE);
   assign go_req    = csr_we && csr_wdata[CS_GO] && csr_wdata[CS_EN] && !busy;
   assign abort_req = csr_we && csr_wdata[CS_ABORT] && en_q && busy;
   assign stop_now  = abort_q || abort_req;

   assign ld_en     = (state_q == ST_FETCH) && mem_ack;
   assign ld_idx    = widx_q;
   assign ld_data   = mem_rdata;
   assign adv       = (state_q == ST_WR) && mem_ack;
   assign irq       = irq_q;
   assign csr_rdata = {3'b000, done_q, 3'b000, en_q};

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_host  = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      mem_be    = '0;
      case (state_q)
         ST_FETCH: begin
            mem_req  = 1'b1;
            mem_host = dsc_host_q;
            mem_addr = {dsc_addr_q[ADDR_W-1:4], widx_q, 2'b00};
            mem_be   = '1;
         end
         ST_RD: begin
            mem_req  = 1'b1;
            mem_host = !dir_l2h;
            mem_addr = dir_l2h ? laddr : haddr;
            mem_be   = beat_be;
         end
         ST_WR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_host  = dir_l2h;
            mem_addr  = dir_l2h ? haddr : laddr;
            mem_wdata = data_q;
            mem_be    = beat_be;
         end
         ST_WB: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_host = dsc_host_q;
            mem_addr = {dsc_addr_q[ADDR_W-1:4], 4'b1000};
            mem_be   = '1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         widx_q     <= '0;
         dsc_addr_q <= '0;
         dsc_host_q <= 1'b0;
         data_q     <= '0;
         en_q       <= 1'b0;
         done_q     <= 1'b1;
         irq_q      <= 1'b0;
         abort_q    <= 1'b0;
      end else begin
         if (csr_we) en_q <= csr_wdata[CS_EN];
         if (csr_we && csr_wdata[CS_ACK]) irq_q <= 1'b0;
         if (abort_req) abort_q <= 1'b1;
         case (state_q)
            ST_IDLE: if (go_req) begin
               done_q  <= 1'b0;
               abort_q <= 1'b0;
               if (chain) begin
                  dsc_addr_q <= {nptr[ADDR_W-1:4], 4'b0000};
                  dsc_host_q <= nptr[NF_HOST];
                  widx_q     <= '0;
                  state_q    <= ST_FETCH;
               end else begin
                  state_q <= ST_XFER;
               end
            end
            ST_FETCH: if (mem_ack) begin
               if (stop_now) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  abort_q <= 1'b0;
               end else if (widx_q == 2'd3) begin
                  state_q <= ST_XFER;
               end else begin
                  widx_q <= widx_q + 2'd1;
               end
            end
            ST_XFER: begin
               if (stop_now) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  abort_q <= 1'b0;
               end else if (cnt_zero) begin
                  state_q <= ST_END;
               end else begin
                  state_q <= ST_RD;
               end
            end
            ST_RD: if (mem_ack) begin
               data_q  <= mem_rdata;
               state_q <= ST_WR;
            end
            ST_WR: if (mem_ack) state_q <= ST_XFER;
            ST_END: state_q <= (chain && mode[MB_CLR_CNT]) ? ST_WB : ST_POST;
            ST_WB: if (mem_ack) state_q <= ST_POST;
            ST_POST: begin
               if (chain && nptr[NF_TCI]) irq_q <= 1'b1;
               if (chain && !nptr[NF_EOC]) begin
                  dsc_addr_q <= {nptr[ADDR_W-1:4], 4'b0000};
                  dsc_host_q <= nptr[NF_HOST];
                  widx_q     <= '0;
                  state_q    <= ST_FETCH;
               end else begin
                  if (mode[MB_DONE_IE]) irq_q <= 1'b1;
                  done_q  <= 1'b1;
                  abort_q <= 1'b0;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R5
   AST_BE_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_be != '0 && ((mem_be & (mem_be + 1'b1)) == '0))); // R5
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !mem_req); // R11
   AST_GO_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      go_req |=> !done_q); // R3
   AST_GO_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && csr_wdata[CS_GO] && !csr_wdata[CS_EN] && !busy) |=> (done_q && !mem_req)); // R3
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !(csr_we && csr_wdata[CS_ACK])) |=> irq_q); // R9

endmodule

// File: rtl/sgdma_chan.sv
module sgdma_chan
   import sgdma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 23,
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_we,
   input  logic [2:0]            reg_idx,
   input  logic [31:0]           reg_wdata,
   output logic [31:0]           reg_rdata,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic                  mem_host,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [DATA_W-1:0]     mem_wdata,
   output logic [DATA_W/8-1:0]   mem_be,
   input  logic                  mem_ack,
   input  logic [DATA_W-1:0]     mem_rdata,
   output logic                  irq
);
   localparam int BYTES = DATA_W / 8;
   localparam int SW    = $clog2(BYTES);

   if (DATA_W != 32) begin : g_chk_dw
      $error("descriptor words are 32 bits wide");
   end
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_chk_aw
      $error("address width must lie in 8..32");
   end
   if (CNT_W < SW + 1 || CNT_W > 32) begin : g_chk_cw
      $error("count width out of range");
   end

   logic [31:0]        mode;
   logic [ADDR_W-1:0]  haddr, laddr, nptr;
   logic [CNT_W-1:0]   cnt;
   logic [BYTES-1:0]   beat_be;
   logic [SW:0]        step;
   logic               cnt_zero, busy, ld_en, adv;
   logic [1:0]         ld_idx;
   logic [DATA_W-1:0]  ld_data;
   logic [7:0]         csr_rdata;
   logic               host_we, csr_we;

   assign csr_we  = reg_we && (int'(reg_idx) == IDX_CSR);
   assign host_we = reg_we && (int'(reg_idx) < IDX_CSR);

   sgdma_beat #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_beat (
      .cnt (cnt), .be (beat_be), .step (step), .zero (cnt_zero)
   );

   sgdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk (clk), .rst_n (rst_n),
      .host_we (host_we), .host_idx (reg_idx), .host_wdata (reg_wdata),
      .busy (busy), .ld_en (ld_en), .ld_idx (ld_idx), .ld_data (ld_data),
      .adv (adv), .step (step),
      .mode (mode), .haddr (haddr), .laddr (laddr), .cnt (cnt), .nptr (nptr)
   );

   sgdma_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
      .clk (clk), .rst_n (rst_n),
      .csr_we (csr_we), .csr_wdata (reg_wdata[7:0]),
      .mode (mode), .haddr (haddr), .laddr (laddr), .nptr (nptr),
      .cnt_zero (cnt_zero), .beat_be (beat_be),
      .mem_req (mem_req), .mem_we (mem_we), .mem_host (mem_host),
      .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_be (mem_be),
      .mem_ack (mem_ack), .mem_rdata (mem_rdata),
      .ld_en (ld_en), .ld_idx (ld_idx), .ld_data (ld_data), .adv (adv),
      .busy (busy), .csr_rdata (csr_rdata), .irq (irq)
   );

   always_comb begin
      case (int'(reg_idx))
         IDX_MODE:  reg_rdata = mode;
         IDX_HADDR: reg_rdata = 32'(haddr);
         IDX_LADDR: reg_rdata = 32'(laddr);
         IDX_COUNT: reg_rdata = 32'(cnt);
         IDX_NEXT:  reg_rdata = 32'(nptr);
         IDX_CSR:   reg_rdata = {24'h0, csr_rdata};
         default:   reg_rdata = '0;
      endcase
   end

endmodule

// File: tb/test_sgdma_chan.sv
module test_sgdma_chan;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_idx = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we, mem_host;
   logic [31:0] mem_addr, mem_wdata;
   logic [3:0]  mem_be;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        irq;

   always #4 clk = ~clk;

   sgdma_chan i_sgdma_chan (
      .clk (clk), .rst_n (rst_n), .reg_we (reg_we), .reg_idx (reg_idx),
      .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .mem_req (mem_req), .mem_we (mem_we), .mem_host (mem_host),
      .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_be (mem_be),
      .mem_ack (mem_ack), .mem_rdata (mem_rdata), .irq (irq)
   );

   logic [31:0] hmem  [0:255];
   logic [31:0] lmem  [0:255];
   logic [31:0] exp_h [0:255];
   logic [31:0] exp_l [0:255];

   int total = 0;
   int bad = 0;
   int cyc = 0;

   // memory model with random acknowledge latency
   always @(posedge clk) begin
      if (!rst_n) mem_ack <= 1'b0;
      else if (mem_req && !mem_ack && ($urandom_range(0, 3) != 0)) begin
         mem_ack <= 1'b1;
         if (mem_we) begin
            for (int b = 0; b < 4; b++) if (mem_be[b]) begin
               if (mem_host) hmem[mem_addr[9:2]][8*b +: 8] = mem_wdata[8*b +: 8];
               else          lmem[mem_addr[9:2]][8*b +: 8] = mem_wdata[8*b +: 8];
            end
         end else begin
            mem_rdata <= mem_host ? hmem[mem_addr[9:2]] : lmem[mem_addr[9:2]];
         end
      end else mem_ack <= 1'b0;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         total++;
         bad++;
         $display("FAIL watchdog R11: act=%0d cycles exp<150000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", rq, act, exp);
      end
   endtask

   task automatic wr_reg(input int idx, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_idx = idx[2:0]; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_reg(input int idx, output logic [31:0] d);
      reg_idx = idx[2:0];
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_done(input string rq);
      logic [31:0] v;
      int n;
      n = 0;
      do begin
         @(negedge clk);
         rd_reg(5, v);
         n++;
      end while (!v[4] && n < 20000);
      chk(rq, {31'b0, v[4]}, 32'd1);
   endtask

   task automatic fill_rand();
      for (int i = 0; i < 256; i++) begin
         hmem[i] = $urandom;
         lmem[i] = $urandom;
      end
   endtask

   task automatic sync_exp();
      for (int i = 0; i < 256; i++) begin
         exp_h[i] = hmem[i];
         exp_l[i] = lmem[i];
      end
   endtask

   task automatic cmp_mem(input string rq);
      int nh, nl;
      nh = 0; nl = 0;
      for (int i = 0; i < 256; i++) begin
         if (hmem[i] !== exp_h[i]) nh++;
         if (lmem[i] !== exp_l[i]) nl++;
      end
      chk({rq, " host words wrong"}, 32'(nh), 32'd0);
      chk({rq, " local words wrong"}, 32'(nl), 32'd0);
   endtask

   // reference beat-by-beat copy on the expected images
   task automatic ref_move(input bit l2h, input logic [31:0] ha_i, input logic [31:0] la_i,
                           input int cnt_i, input bit hold);
      logic [31:0] ha, la, w;
      int c, n;
      ha = ha_i; la = la_i; c = cnt_i;
      while (c > 0) begin
         n = (c >= 4) ? 4 : c;
         w = l2h ? exp_l[la[9:2]] : exp_h[ha[9:2]];
         for (int b = 0; b < n; b++) begin
            if (l2h) exp_h[ha[9:2]][8*b +: 8] = w[8*b +: 8];
            else     exp_l[la[9:2]][8*b +: 8] = w[8*b +: 8];
         end
         ha += 4;
         if (!hold) la += 4;
         c -= n;
      end
   endtask

   task automatic put_word(input bit host, input logic [31:0] a, input logic [31:0] v);
      if (host) hmem[a[9:2]] = v;
      else      lmem[a[9:2]] = v;
   endtask

   task automatic run_direct(input logic [31:0] md, input logic [31:0] ha, input logic [31:0] la,
                             input int cnt, input bit l2h);
      wr_reg(0, md);
      wr_reg(1, ha);
      wr_reg(2, la);
      wr_reg(3, 32'(cnt));
      wr_reg(4, l2h ? 32'h8 : 32'h0);
      sync_exp();
      ref_move(l2h, ha, la, cnt, md[11]);
      wr_reg(5, 32'h3);
   endtask

   logic [31:0] v;
   logic [31:0] da [0:3];
   bit          dh [0:3];
   bit          dr [0:3];
   int          cn [0:3];
   int          nd;
   bit          clr;
   logic [31:0] md, nx;
   int          seen;

   initial begin
      v = $urandom(32'h5eed);
      fill_rand();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      rd_reg(5, v); chk("R1 status after reset", v, 32'h10);
      rd_reg(0, v); chk("R1 mode after reset", v, 32'h0);
      rd_reg(3, v); chk("R1 count after reset", v, 32'h0);
      chk("R1 irq after reset", {31'b0, irq}, 32'h0);
      chk("R1 mem_req after reset", {31'b0, mem_req}, 32'h0);

      // direct host to local, whole words, done interrupt enabled
      fill_rand();
      run_direct(32'h400, 32'h40, 32'h80, 16, 1'b0);
      wait_done("R4 direct done");
      cmp_mem("R4 direct host-to-local");
      rd_reg(3, v); chk("R11 count zero after direct", v, 32'h0);
      chk("R9 irq on completion", {31'b0, irq}, 32'h1);
      wr_reg(5, 32'h9);
      chk("R9 irq cleared by bit 3", {31'b0, irq}, 32'h0);
      rd_reg(5, v); chk("R12 status layout enable+done", v, 32'h11);

      // local to host with a partial final beat, no interrupt
      fill_rand();
      run_direct(32'h0, 32'h60, 32'hC0, 7, 1'b1);
      wait_done("R5 partial done");
      cmp_mem("R5 partial beat local-to-host");
      chk("R9 no irq without enable", {31'b0, irq}, 32'h0);

      // local address held constant
      fill_rand();
      run_direct(32'h800, 32'h0, 32'h20, 12, 1'b0);
      wait_done("R5 hold done");
      cmp_mem("R5 hold local address");
      rd_reg(2, v); chk("R5 local address unchanged", v, 32'h20);
      rd_reg(1, v); chk("R5 host address advanced", v, 32'hC);

      // zero count
      fill_rand();
      run_direct(32'h400, 32'h10, 32'h10, 0, 1'b0);
      wait_done("R5 zero count done");
      cmp_mem("R5 zero count moves nothing");
      chk("R9 irq on empty transfer", {31'b0, irq}, 32'h1);
      wr_reg(5, 32'h9);

      // start without enable is ignored
      fill_rand();
      sync_exp();
      wr_reg(0, 32'h0); wr_reg(1, 32'h0); wr_reg(2, 32'h0); wr_reg(3, 32'd32); wr_reg(4, 32'h0);
      wr_reg(5, 32'h2);
      seen = 0;
      repeat (20) begin
         @(negedge clk);
         if (mem_req) seen++;
      end
      chk("R3 no request after start without enable", 32'(seen), 32'h0);
      rd_reg(5, v); chk("R3 done kept after ignored start", v, 32'h10);
      cmp_mem("R3 memory untouched");

      // configuration writes ignored while busy
      fill_rand();
      run_direct(32'h0, 32'h100, 32'h200, 64, 1'b0);
      wr_reg(0, 32'hFFFF_FFFF);
      wr_reg(1, 32'h3FC);
      wait_done("R2 busy run done");
      rd_reg(0, v); chk("R2 mode kept while busy", v, 32'h0);
      rd_reg(1, v); chk("R2 host address not overwritten", v, 32'h140);
      cmp_mem("R2 data intact");

      // abort with enable set
      fill_rand();
      wr_reg(0, 32'h400); wr_reg(1, 32'h0); wr_reg(2, 32'h0); wr_reg(3, 32'd256); wr_reg(4, 32'h0);
      sync_exp();
      wr_reg(5, 32'h3);
      repeat (20) @(negedge clk);
      wr_reg(5, 32'h5);
      wait_done("R10 abort reaches done");
      rd_reg(3, v);
      chk("R10 stopped early", {31'b0, (v != 0 && v < 256)}, 32'h1);
      ref_move(1'b0, 32'h0, 32'h0, 256 - int'(v), 1'b0);
      cmp_mem("R10 abort on beat boundary");
      chk("R10 no irq on abort", {31'b0, irq}, 32'h0);
      repeat (5) @(negedge clk);
      chk("R10 quiet after abort", {31'b0, mem_req}, 32'h0);

      // abort with enable clear is ignored
      fill_rand();
      run_direct(32'h0, 32'h80, 32'h180, 64, 1'b0);
      wr_reg(5, 32'h0);
      wr_reg(5, 32'h4);
      wait_done("R10 disabled abort run done");
      rd_reg(3, v); chk("R10 ignored abort, count zero", v, 32'h0);
      cmp_mem("R10 ignored abort, full copy");

      // chain: per-descriptor interrupt flag, no write-back
      fill_rand();
      da[0] = 32'h340; dh[0] = 1'b0; da[1] = 32'h350; dh[1] = 1'b1;
      put_word(0, 32'h340, 32'h10); put_word(0, 32'h344, 32'h110);
      put_word(0, 32'h348, 32'd8);  put_word(0, 32'h34C, 32'h350 | 32'h1 | 32'h4);
      put_word(1, 32'h350, 32'h20); put_word(1, 32'h354, 32'h120);
      put_word(1, 32'h358, 32'd5);  put_word(1, 32'h35C, 32'h2 | 32'h8);
      sync_exp();
      ref_move(1'b0, 32'h10, 32'h110, 8, 1'b0);
      ref_move(1'b1, 32'h20, 32'h120, 5, 1'b0);
      wr_reg(0, 32'h200); wr_reg(4, 32'h340);
      wr_reg(5, 32'h3);
      wait_done("R7 flagged chain done");
      cmp_mem("R8 chain without write-back");
      chk("R9 irq from descriptor flag", {31'b0, irq}, 32'h1);
      wr_reg(5, 32'h9);

      // random chains
      for (int it = 0; it < 5; it++) begin
         fill_rand();
         nd  = 1 + int'($urandom % 3);
         clr = bit'($urandom % 2);
         for (int k = 0; k < 4; k++) begin
            da[k] = 32'h300 + 32'(k * 16);
            dh[k] = bit'($urandom % 2);
            dr[k] = bit'($urandom % 2);
            cn[k] = int'($urandom % 41);
         end
         for (int k = 0; k < nd; k++) begin
            nx = (k == nd - 1) ? 32'h2 : (da[k+1] | 32'(dh[k+1]));
            nx = nx | (32'(dr[k]) << 3);
            put_word(dh[k], da[k],      32'(k * 128));
            put_word(dh[k], da[k] + 4,  32'h100 + 32'(k * 128));
            put_word(dh[k], da[k] + 8,  32'(cn[k]) | 32'hA580_0000);
            put_word(dh[k], da[k] + 12, nx);
         end
         sync_exp();
         for (int k = 0; k < nd; k++) begin
            ref_move(dr[k], 32'(k * 128), 32'h100 + 32'(k * 128), cn[k], 1'b0);
            if (clr) begin
               if (dh[k]) exp_h[(da[k] + 8) >> 2] = 32'h0;
               else       exp_l[(da[k] + 8) >> 2] = 32'h0;
            end
         end
         md = 32'h600 | (32'(clr) << 16);
         wr_reg(0, md);
         wr_reg(4, da[0] | 32'(dh[0]));
         wr_reg(5, 32'h3);
         wait_done("R7 random chain done");
         cmp_mem("R6 R8 random chain memory");
         chk("R9 irq after random chain", {31'b0, irq}, 32'h1);
         wr_reg(5, 32'h9);
         chk("R9 irq cleared after chain", {31'b0, irq}, 32'h0);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule